// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block holds the timing and counting logic of a dual-slope integrating analog-to-digital converter. The integrator, the analog switches and the comparator sit outside the block. The sequencer decides which switch is closed in each phase, counts clocks, watches the comparator, and reports how long the integrator takes to discharge. That discharge time is the conversion result.

A conversion starts with a one-cycle `start` pulse while the sequencer is in `ST_IDLE`. The sequencer then moves through the following states:

- `ST_AUTOZERO`: the integrator is shorted for a fixed number of clocks.
- `ST_INTEGRATE`: the unknown input is applied for a programmed number of clocks, `int_len`. This window can be set to a whole number of mains periods so that power-line interference integrates to zero.
- `ST_DEINTEGRATE`: the opposite-polarity reference is applied. Clocks are counted until the synchronized comparator reports that the integrator has returned to its starting level.
- `ST_DONE`: a one-cycle state that carries the result and the `done` strobe, then goes back to `ST_IDLE`.

The transitions are:

- IDLE→AUTOZERO on `start`.
- AUTOZERO→INTEGRATE after `AZ_LEN` cycles.
- INTEGRATE→DEINTEGRATE after the latched window length.
- DEINTEGRATE→DONE on comparator return or on overrange timeout.
- DONE→IDLE unconditionally.

Each result needs both a charge phase and a discharge phase, so conversions are slow compared with other converter types. In exchange, the result does not depend on the value of the integrating capacitor.

Top module: `dslope_adc_seq`

## Requirements
- R1: After reset, `sw_zero` is 1, `sw_input`, `sw_ref` and `done` are 0, `result` is 0 and `overrange` is 0.
- R2: A `start` sampled high in `ST_IDLE` begins a conversion. The first `AZ_LEN` cycles are auto-zero, with only `sw_zero` high, and they are followed directly by the integrate phase.
- R3: `sw_input` is high for exactly `int_len` consecutive cycles, using the value latched when the start was accepted. An `int_len` of 0 acts as 1. The reference phase follows immediately.
- R4: Exactly one of `sw_zero`, `sw_input` and `sw_ref` is high in every cycle.
- R5: `cmp_return` (1 = integrator at or past its start level) passes through `SYNC_STAGES` flip-flops. The first `SYNC_STAGES` de-integration cycles ignore the comparator. The phase then ends on the first high synchronized sample, and `sw_ref` has been high for `result + SYNC_STAGES + 1` cycles.
- R6: With an ideal integrator that rises by `a` per input cycle and falls by `b` per reference cycle, `result` equals ceil(`int_len`·`a`/`b`). This gives 0 for a zero input.
- R7: If the comparator has not returned by count `DEINT_MAX`, the conversion ends with `overrange` = 1 and `result` = `DEINT_MAX`, after `sw_ref` has been high for `DEINT_MAX + SYNC_STAGES + 1` cycles. A result of exactly `DEINT_MAX` is in range, with `overrange` = 0.
- R8: `done` is high for exactly one cycle, in the cycle right after the last `sw_ref` cycle, and the block then returns to idle with `sw_zero` high. `result` and `overrange` change only when that cycle begins and hold until the next conversion ends.
- R9: `start` is ignored while a conversion is in progress. It neither shortens nor extends any phase, and it does not queue a second conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a conversion when the block is idle |
| int_len | input | LEN_W | Integrate window in clocks (0 acts as 1) |
| cmp_return | input | 1 | Asynchronous comparator: integrator back at start level |
| sw_zero | output | 1 | Close the integrator shorting switch |
| sw_input | output | 1 | Connect the unknown input to the integrator |
| sw_ref | output | 1 | Connect the opposite-polarity reference |
| done | output | 1 | One-cycle strobe marking a new result |
| result | output | RES_W | De-integration count |
| overrange | output | 1 | Last conversion exceeded `DEINT_MAX` |

## Verification
The bench builds the block with `LEN_W` = 8, `DEINT_MAX` = 200, `AZ_LEN` = 4 and `SYNC_STAGES` = 2. These values keep each conversion to a few hundred cycles. As a result, the exact full-scale count, the first overranging count, a zero input, a zero-length window and a start pulse injected mid-conversion can all be driven alongside dozens of random conversions. An ideal ramp model supplies the comparator, so the expected count follows from the ceiling formula and the expected phase lengths follow from the parameters.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_AUTOZERO    = 3'd1,
        ST_INTEGRATE   = 3'd2,
        ST_DEINTEGRATE = 3'd3,
        ST_DONE        = 3'd4
    } seq_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/dslope_timer.sv
module dslope_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
    import dslope_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int CNT_W       = 16,
    parameter int RES_W       = 12,
    parameter int AZ_LEN      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DEINT_MAX   = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] int_len,
    input  logic             cmp_sync,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             sw_zero,
    output logic             sw_input,
    output logic             sw_ref,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             overrange
);

    localparam logic [CNT_W-1:0] AZ_LAST = CNT_W'(AZ_LEN - 1);
    localparam logic [CNT_W-1:0] BLANK   = CNT_W'(SYNC_STAGES);
    localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(SYNC_STAGES + DEINT_MAX);

    seq_state_e       state, nxt;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] len_last;
    logic             ret_seen;
    logic             timeout;

    assign len_last = CNT_W'(len_q) - CNT_W'(1);
    assign ret_seen = cmp_sync && (cnt >= BLANK);
    assign timeout  = !ret_seen && (cnt == LIMIT);

    // State register, window latch and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            len_q     <= LEN_W'(1);
            result    <= '0;
            overrange <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                len_q <= (int_len == '0) ? LEN_W'(1) : int_len;
            end
            if (state == ST_DEINTEGRATE) begin
                if (ret_seen) begin
                    result    <= RES_W'(cnt - BLANK);
                    overrange <= 1'b0;
                end else if (timeout) begin
                    result    <= RES_W'(DEINT_MAX);
                    overrange <= 1'b1;
                end
            end
        end
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:        if (start)             nxt = ST_AUTOZERO;
            ST_AUTOZERO:    if (cnt == AZ_LAST)    nxt = ST_INTEGRATE;
            ST_INTEGRATE:   if (cnt == len_last)   nxt = ST_DEINTEGRATE;
            ST_DEINTEGRATE: if (ret_seen || timeout) nxt = ST_DONE;
            ST_DONE:                               nxt = ST_IDLE;
            default:                               nxt = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        sw_zero  = 1'b0;
        sw_input = 1'b0;
        sw_ref   = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:        sw_zero  = 1'b1;
            ST_AUTOZERO:    sw_zero  = 1'b1;
            ST_INTEGRATE:   sw_input = 1'b1;
            ST_DEINTEGRATE: sw_ref   = 1'b1;
            ST_DONE: begin
                sw_zero = 1'b1;
                done    = 1'b1;
            end
            default:        sw_zero  = 1'b1;
        endcase
        cnt_clr = (nxt != state) || (state == ST_IDLE);
    end

endmodule

// File: rtl/dslope_adc_seq.sv
module dslope_adc_seq
    import dslope_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int DEINT_MAX   = 4000,
    parameter int AZ_LEN      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int RES_W       = $clog2(DEINT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] int_len,
    input  logic             cmp_return,
    output logic             sw_zero,
    output logic             sw_input,
    output logic             sw_ref,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             overrange
);

    localparam int CNT_W = max_int(LEN_W, $clog2(SYNC_STAGES + DEINT_MAX + 1)) + 1;

    logic             cmp_sync;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;

    dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(cmp_return),
        .q_sync (cmp_sync)
    );

    dslope_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .cnt  (cnt)
    );

    dslope_fsm #(
        .LEN_W      (LEN_W),
        .CNT_W      (CNT_W),
        .RES_W      (RES_W),
        .AZ_LEN     (AZ_LEN),
        .SYNC_STAGES(SYNC_STAGES),
        .DEINT_MAX  (DEINT_MAX)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .int_len  (int_len),
        .cmp_sync (cmp_sync),
        .cnt      (cnt),
        .cnt_clr  (cnt_clr),
        .sw_zero  (sw_zero),
        .sw_input (sw_input),
        .sw_ref   (sw_ref),
        .done     (done),
        .result   (result),
        .overrange(overrange)
    );

endmodule

// File: rtl/dslope_adc_seq_chk.sv
module dslope_adc_seq_chk #(
    parameter int RES_W     = 12,
    parameter int DEINT_MAX = 4000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_zero,
    input logic             sw_input,
    input logic             sw_ref,
    input logic             done,
    input logic [RES_W-1:0] result,
    input logic             overrange
);

    a_r4_switch_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({sw_zero, sw_input, sw_ref}));

    a_r2_zero_before_input: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_input) |-> $past(sw_zero));

    a_r3_input_before_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_ref) |-> $past(sw_input));

    a_r8_done_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(sw_ref));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(overrange)));

    a_r7_ovr_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overrange) |-> (result == RES_W'(DEINT_MAX)));

    a_r7_result_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result <= RES_W'(DEINT_MAX)));

endmodule

bind dslope_adc_seq dslope_adc_seq_chk #(
    .RES_W    (RES_W),
    .DEINT_MAX(DEINT_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_zero  (sw_zero),
    .sw_input (sw_input),
    .sw_ref   (sw_ref),
    .done     (done),
    .result   (result),
    .overrange(overrange)
);

// File: tb/tb_dslope_adc_seq.sv
module tb_dslope_adc_seq;

    localparam int LEN_W       = 8;
    localparam int DEINT_MAX   = 200;
    localparam int AZ_LEN      = 4;
    localparam int SYNC_STAGES = 2;
    localparam int RES_W       = $clog2(DEINT_MAX + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] int_len = '0;
    logic             cmp_return;
    logic             sw_zero, sw_input, sw_ref, done, overrange;
    logic [RES_W-1:0] result;

    int vin_step = 0;
    int ref_step = 8;
    int integ    = 0;
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dslope_adc_seq #(
        .LEN_W      (LEN_W),
        .DEINT_MAX  (DEINT_MAX),
        .AZ_LEN     (AZ_LEN),
        .SYNC_STAGES(SYNC_STAGES)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .int_len   (int_len),
        .cmp_return(cmp_return),
        .sw_zero   (sw_zero),
        .sw_input  (sw_input),
        .sw_ref    (sw_ref),
        .done      (done),
        .result    (result),
        .overrange (overrange)
    );

    // Ideal integrator and comparator
    always @(posedge clk) begin
        if (sw_zero)       integ <= 0;
        else if (sw_input) integ <= integ + vin_step;
        else if (sw_ref)   integ <= integ - ref_step;
    end
    assign cmp_return = (integ <= 0);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_count(input int len, input int a, input int b);
        int le = (len == 0) ? 1 : len;
        return (le * a + b - 1) / b;
    endfunction

    task automatic convert(input int len, input int a, input int b, input bit poke);
        int az = 0, ni = 0, nr = 0, guard = 0;
        bit overlap = 1'b0;
        bit stray = 1'b0;
        int le   = (len == 0) ? 1 : len;
        int ec   = exp_count(len, a, b);
        bit eovr = (ec > DEINT_MAX);
        int eres = eovr ? DEINT_MAX : ec;
        int_len  = LEN_W'(len);
        vin_step = a;
        ref_step = b;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && guard < 2000) begin
            if (!$onehot({sw_zero, sw_input, sw_ref})) overlap = 1'b1;
            if (sw_zero)  az++;
            if (sw_input) ni++;
            if (sw_ref)   nr++;
            start = (poke && sw_input && ni == 1) || (poke && sw_ref && nr == 1);
            int_len = poke ? LEN_W'(len + 7) : int_len;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        check(guard < 2000, "R8 done reached", guard, 0);
        check(az == AZ_LEN, "R2 auto-zero length", az, AZ_LEN);
        check(ni == le, "R3 integrate window", ni, le);
        check(!overlap, "R4 one-hot switches", int'(overlap), 0);
        check(int'(result) == eres, "R6 result", int'(result), eres);
        check(overrange == eovr, "R7 overrange flag", int'(overrange), int'(eovr));
        check(nr == eres + SYNC_STAGES + 1, "R5 reference cycles", nr, eres + SYNC_STAGES + 1);
        @(negedge clk);
        check(!done && sw_zero, "R8 single-cycle done then idle", int'(done), 0);
        for (int i = 0; i < 6; i++) begin
            if (!sw_zero || done) stray = 1'b1;
            check(int'(result) == eres, "R8 result held", int'(result), eres);
            @(negedge clk);
        end
        if (poke) check(!stray, "R9 start ignored mid-conversion", int'(stray), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sw_zero && !sw_input && !sw_ref, "R1 switches at reset", int'(sw_zero), 1);
        check(!done && result == '0 && !overrange, "R1 outputs at reset", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        convert(0, 8, 8, 1'b0);        // R3 zero window acts as one
        convert(50, 0, 8, 1'b0);       // R6 zero input
        convert(5, 3, 8, 1'b0);        // R6 ceiling of a fraction
        convert(200, 8, 8, 1'b0);      // R7 exactly full scale
        convert(201, 8, 8, 1'b0);      // R7 first overrange count
        convert(255, 15, 4, 1'b0);     // R7 deep overrange
        convert(60, 6, 5, 1'b1);       // R9 start poked mid-conversion
        convert(1, 1, 16, 1'b0);       // R5 return seen after blanking

        for (int k = 0; k < 30; k++) begin
            int l = int'($urandom_range(1, 255));
            int a = int'($urandom_range(0, 15));
            int b = int'($urandom_range(4, 16));
            convert(l, a, b, k[2]);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule